// File: doc/BRIEF.md
# PHY Test-Port Rate Configuration Sequencer

This block brings a two-lane high-speed serial receiver PHY out of shutdown with the correct analog rate setting. It drives the PHY's four-wire test port, made up of a clear strobe, a test clock, an enable and an 8-bit data bus. When software asks for a start, the block first confirms that the PHY is still powered down. It then turns the requested line rate in Mbps into a 6-bit range code and performs the write on the test port. The write has a clear pulse, then an address phase that selects the rate register, then a data phase that carries the code. After that the block waits out an analog settling interval and raises a ready flag. The ready flag allows low-power command decoding to begin.

The lane count, one or two, sits in a small register beside the sequencer. That register takes a new value only while the PHY is in shutdown. The block refuses a start request in two cases: when the PHY is not in shutdown, and when the requested rate lies outside the supported span. In either case it raises a sticky error flag and leaves the test port idle. Every level on the test port is held for a programmable number of system clocks, so each edge has margin against the PHY's setup and hold windows.

Top module: `phy_cfg_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, testclr_o, testclk_o and testen_o are low. busy_o, done_o, err_o and ready_o are low, and lanes_o reads 2. A reset asserted in the middle of a sequence returns all of these to the same values.
- R2: lane_cnt_i is written to lanes_o only when lane_wr_i is high, shutdown_i is high and the value is 1 (one lane) or 2 (two lanes). Any other value, and any write while shutdown_i is low, leaves lanes_o unchanged.
- R3: A start with shutdown_i low sets err_o on the next cycle and keeps busy_o low. No edge then appears on testclr_o or testclk_o.
- R4: A start with rate_mbps_i below 80 or above 1500 has the same effect as in R3.
- R5: An accepted sequence begins with exactly one high pulse on testclr_o, and this pulse comes before testclk_o first rises. The first falling edge of testclk_o occurs with testen_o high and testdin_o equal to 8'h44.
- R6: The second and last falling edge of testclk_o in a sequence occurs with testen_o low. At that edge testdin_o[5:0] holds the rate code and testdin_o[7:6] is 0.
- R7: The rate code follows the range table, for example: 80 and 89 give 6'b000000; 90 gives 6'b010000; 110 and 129 give 6'b000001; 400 and 449 give 6'b000110; 1000 and 1049 give 6'b101010; 1450 and 1500 give 6'b111100.
- R8: The testclr_o pulse lasts exactly HOLD_CYC clocks. The high phase of the data-write testclk_o pulse also lasts exactly HOLD_CYC clocks.
- R9: ready_o rises exactly HOLD_CYC + CLK_MHZ*INIT_US clocks after the final falling edge of testclk_o.
- R10: busy_o is high from the cycle after an accepted start until ready_o rises, and it is low from then on. done_o is high for exactly one cycle, and that cycle is the one in which ready_o rises.
- R11: A start request while busy_o is high is ignored. The sequence that is running keeps its code, its single clear pulse and its timing.
- R12: err_o stays high until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled each clock |
| rate_mbps_i | input | 11 | Requested high-speed rate in Mbps |
| shutdown_i | input | 1 | High while the PHY is in shutdown |
| lane_wr_i | input | 1 | Lane-count write strobe |
| lane_cnt_i | input | 2 | Lane count to write (1 or 2) |
| lanes_o | output | 2 | Configured lane count |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky refusal flag |
| ready_o | output | 1 | Low-power command decoding may begin |
| testclr_o | output | 1 | PHY test clear strobe |
| testclk_o | output | 1 | PHY test clock |
| testen_o | output | 1 | PHY test enable (address phase) |
| testdin_o | output | 8 | PHY test data bus |

## Verification
Two functions can act in the same clock: a lane-count write and a start request. The bench provokes this by raising both strobes together while shutdown_i is high, and again while it is low. With shutdown_i high, lanes_o must take the new value and the sequence must start with the correct code. With shutdown_i low, lanes_o must keep its old value and err_o must rise with busy_o held low. A second start request is also issued in the middle of a sequence. That case is judged by decoding the test-port waveform, which must show a single clear pulse and the first code.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

    localparam int RATE_W    = 11;
    localparam int DIN_W     = 8;
    localparam int CODE_W    = 6;
    localparam int NUM_BANDS = 39;
    localparam int RATE_MIN  = 80;
    localparam int RATE_MAX  = 1500;
    localparam logic [DIN_W-1:0] RATE_REG_ADDR = 8'h44;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR_HI,
        ST_CLR_LO,
        ST_CK_HI,
        ST_ADDR_SET,
        ST_ADDR_FALL,
        ST_DATA_SET,
        ST_DATA_RISE,
        ST_DATA_FALL,
        ST_INIT_WAIT,
        ST_READY
    } seq_state_e;

    typedef struct packed {
        logic             clr;
        logic             tck;
        logic             en;
        logic [DIN_W-1:0] din;
    } tport_t;

    // Lowest rate of each band, ascending.
    localparam logic [RATE_W-1:0] BAND_LO [NUM_BANDS] = '{
        11'd80,   11'd90,   11'd100,  11'd110,  11'd130,  11'd140,  11'd150,
        11'd170,  11'd180,  11'd200,  11'd220,  11'd240,  11'd250,  11'd270,
        11'd300,  11'd330,  11'd360,  11'd400,  11'd450,  11'd500,  11'd550,
        11'd600,  11'd650,  11'd700,  11'd750,  11'd800,  11'd850,  11'd900,
        11'd950,  11'd1000, 11'd1050, 11'd1100, 11'd1150, 11'd1200, 11'd1250,
        11'd1300, 11'd1350, 11'd1400, 11'd1450
    };

    // Code of each band: {2-bit sub-range prefix, 4-bit band index}.
    localparam logic [CODE_W-1:0] BAND_CODE [NUM_BANDS] = '{
        6'b000000, 6'b010000, 6'b100000, 6'b000001, 6'b010001, 6'b100001,
        6'b000010, 6'b010010, 6'b100010, 6'b000011, 6'b010011, 6'b100011,
        6'b000100, 6'b010100, 6'b000101, 6'b010101, 6'b100101, 6'b000110,
        6'b010110, 6'b000111, 6'b010111, 6'b001000, 6'b011000, 6'b001001,
        6'b011001, 6'b101001, 6'b111001, 6'b001010, 6'b011010, 6'b101010,
        6'b111010, 6'b001011, 6'b011011, 6'b101011, 6'b111011, 6'b001100,
        6'b011100, 6'b101100, 6'b111100
    };

    function automatic logic rate_in_span(input logic [RATE_W-1:0] r);
        return (r >= RATE_W'(RATE_MIN)) && (r <= RATE_W'(RATE_MAX));
    endfunction

    // Highest band whose lower bound does not exceed the rate wins.
    function automatic logic [CODE_W-1:0] rate_code(input logic [RATE_W-1:0] r);
        logic [CODE_W-1:0] c;
        c = BAND_CODE[0];
        for (int i = 0; i < NUM_BANDS; i++) begin
            if (r >= BAND_LO[i]) c = BAND_CODE[i];
        end
        return c;
    endfunction

    function automatic seq_state_e next_step(input seq_state_e s);
        case (s)
            ST_CLR_HI:    return ST_CLR_LO;
            ST_CLR_LO:    return ST_CK_HI;
            ST_CK_HI:     return ST_ADDR_SET;
            ST_ADDR_SET:  return ST_ADDR_FALL;
            ST_ADDR_FALL: return ST_DATA_SET;
            ST_DATA_SET:  return ST_DATA_RISE;
            ST_DATA_RISE: return ST_DATA_FALL;
            ST_DATA_FALL: return ST_INIT_WAIT;
            ST_INIT_WAIT: return ST_READY;
            default:      return s;
        endcase
    endfunction

    function automatic tport_t port_levels(input seq_state_e s,
                                           input logic [CODE_W-1:0] code);
        tport_t p;
        logic [DIN_W-1:0] dword;
        dword = {{(DIN_W-CODE_W){1'b0}}, code};
        p     = '0;
        case (s)
            ST_CLR_HI:    p.clr = 1'b1;
            ST_CK_HI:     p.tck = 1'b1;
            ST_ADDR_SET:  begin p.tck = 1'b1; p.en = 1'b1; p.din = RATE_REG_ADDR; end
            ST_ADDR_FALL: begin p.en = 1'b1; p.din = RATE_REG_ADDR; end
            ST_DATA_SET:  p.din = dword;
            ST_DATA_RISE: begin p.tck = 1'b1; p.din = dword; end
            ST_DATA_FALL: p.din = dword;
            ST_INIT_WAIT: p.din = dword;
            default:      p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/phy_rate_map.sv
module phy_rate_map
    import phy_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_i,
    output logic [CODE_W-1:0] code_o,
    output logic              valid_o
);

    always_comb begin
        valid_o = rate_in_span(rate_i);
        code_o  = rate_code(rate_i);
    end

    AST_BAND_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (code_o[3:0] <= 4'd12)); // R7

endmodule

// File: rtl/phy_step_timer.sv
module phy_step_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load_i)      cnt_q <= load_val_i;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8

endmodule

// File: rtl/phy_lane_reg.sv
module phy_lane_reg (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_i,
    input  logic [1:0] val_i,
    input  logic       shut_i,
    output logic [1:0] lanes_o
);

    logic legal;

    assign legal = (val_i == 2'd1) || (val_i == 2'd2);

    always_ff @(posedge clk) begin
        if (rst)                          lanes_o <= 2'd2;
        else if (wr_i && shut_i && legal) lanes_o <= val_i;
    end

    AST_LANES_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (lanes_o == 2'd1) || (lanes_o == 2'd2)); // R2

    AST_LANES_ONLY_IN_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !shut_i) |=> $stable(lanes_o)); // R2

endmodule

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq
    import phy_cfg_pkg::*;
#(
    parameter int HOLD_CYC = 4,
    parameter int CLK_MHZ  = 200,
    parameter int INIT_US  = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_mbps_i,
    input  logic              shutdown_i,
    input  logic              lane_wr_i,
    input  logic [1:0]        lane_cnt_i,
    output logic [1:0]        lanes_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              ready_o,
    output logic              testclr_o,
    output logic              testclk_o,
    output logic              testen_o,
    output logic [DIN_W-1:0]  testdin_o
);

    localparam int INIT_CYC = CLK_MHZ * INIT_US;
    localparam int MAX_LD   = (INIT_CYC > HOLD_CYC) ? INIT_CYC : HOLD_CYC;
    localparam int TMR_W    = $clog2(MAX_LD + 1);
    localparam logic [TMR_W-1:0] HOLD_LD = TMR_W'(HOLD_CYC - 1);
    localparam logic [TMR_W-1:0] INIT_LD = TMR_W'(INIT_CYC - 1);

    seq_state_e        state_q;
    seq_state_e        nxt;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] map_code;
    logic              map_ok;
    logic              err_q;
    logic              done_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              timed;
    logic              idle_like;
    logic              accept;
    logic              refuse;
    tport_t            port;

    phy_rate_map u_map (
        .clk     (clk),
        .rst     (rst),
        .rate_i  (rate_mbps_i),
        .code_o  (map_code),
        .valid_o (map_ok)
    );

    phy_step_timer #(.W(TMR_W)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    phy_lane_reg u_lanes (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (lane_wr_i),
        .val_i   (lane_cnt_i),
        .shut_i  (shutdown_i),
        .lanes_o (lanes_o)
    );

    always_comb begin
        idle_like = (state_q == ST_IDLE) || (state_q == ST_READY);
        timed     = !idle_like;
        accept    = idle_like && start_i && shutdown_i && map_ok;
        refuse    = idle_like && start_i && !(shutdown_i && map_ok);
        nxt       = next_step(state_q);
        tmr_load  = 1'b0;
        tmr_val   = HOLD_LD;
        if (accept) begin
            tmr_load = 1'b1;
        end else if (timed && tmr_zero) begin
            tmr_load = 1'b1;
            tmr_val  = (nxt == ST_INIT_WAIT) ? INIT_LD : HOLD_LD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q <= ST_CLR_HI;
                code_q  <= map_code;
                err_q   <= 1'b0;
            end else if (refuse) begin
                err_q   <= 1'b1;
            end else if (timed && tmr_zero) begin
                state_q <= nxt;
                if (state_q == ST_INIT_WAIT) done_q <= 1'b1;
            end
        end
    end

    assign port      = port_levels(state_q, code_q);
    assign testclr_o = port.clr;
    assign testclk_o = port.tck;
    assign testen_o  = port.en;
    assign testdin_o = port.din;
    assign busy_o    = timed;
    assign ready_o   = (state_q == ST_READY);
    assign done_o    = done_q;
    assign err_o     = err_q;

    AST_ADDR_DURING_ENABLE: assert property (@(posedge clk) disable iff (rst)
        testen_o |-> (testdin_o == RATE_REG_ADDR)); // R5

    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (rst)
        testclr_o |-> (!testclk_o && !testen_o)); // R5

    AST_BUSY_EXCLUDES_READY: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !ready_o); // R10

    AST_DONE_ON_READY_RISE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $rose(ready_o)); // R10

    AST_REFUSE_NOT_SHUT: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !shutdown_i) |=> (err_o && !busy_o)); // R3

    AST_REFUSE_BAD_RATE: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !map_ok) |=> (err_o && !busy_o)); // R4

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(code_q)); // R11

endmodule

// File: tb/phy_cfg_seq_tb.sv
module phy_cfg_seq_tb;

    localparam int HOLD = 3;
    localparam int MHZ  = 200;
    localparam int US   = 1;
    localparam int INIT = MHZ * US;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [10:0] rate = 11'd0;
    logic        shut = 1'b1;
    logic        lwr = 1'b0;
    logic [1:0]  lval = 2'd0;
    logic [1:0]  lanes_o;
    logic        busy_o, done_o, err_o, ready_o;
    logic        testclr_o, testclk_o, testen_o;
    logic [7:0]  testdin_o;

    int n_chk = 0;
    int n_fail = 0;
    bit timed_out = 1'b0;

    always #2.5 clk = ~clk;

    phy_cfg_seq #(.HOLD_CYC(HOLD), .CLK_MHZ(MHZ), .INIT_US(US)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .rate_mbps_i(rate),
        .shutdown_i(shut), .lane_wr_i(lwr), .lane_cnt_i(lval),
        .lanes_o(lanes_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .ready_o(ready_o), .testclr_o(testclr_o), .testclk_o(testclk_o),
        .testen_o(testen_o), .testdin_o(testdin_o)
    );

    // Test-port monitor, sampled at falling clock edges
    bit mon_clr = 1'b0;
    int cyc = 0;
    int clr_rises, clr_run, clr_w, clk_run, clk_w_data;
    int addr_falls, data_falls, addr_cap, data_cap, data_en, fall_cyc;
    int ready_cyc, busy_at_ready, done_at_ready, done_hi, clr_first;
    logic p_clr = 1'b0, p_clk = 1'b0, p_rdy = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            clr_rises = 0; clr_run = 0; clr_w = 0; clk_run = 0; clk_w_data = 0;
            addr_falls = 0; data_falls = 0; addr_cap = -1; data_cap = -1;
            data_en = -1; fall_cyc = 0; ready_cyc = 0; busy_at_ready = -1;
            done_at_ready = -1; done_hi = 0; clr_first = 0;
        end else begin
            if (testclr_o && !p_clr) clr_rises++;
            if (testclr_o) clr_run++;
            else if (p_clr) begin clr_w = clr_run; clr_run = 0; end
            if (testclk_o && !p_clk && clk_run == 0 && addr_falls == 0)
                clr_first = (clr_rises == 1 && !testclr_o) ? 1 : 0;
            if (testclk_o) clk_run++;
            if (!testclk_o && p_clk) begin
                if (addr_falls == 0) begin
                    addr_falls = 1;
                    addr_cap = testen_o ? int'(testdin_o) : -2;
                end else begin
                    data_falls++;
                    data_cap = int'(testdin_o);
                    data_en = int'(testen_o);
                    clk_w_data = clk_run;
                    fall_cyc = cyc;
                end
                clk_run = 0;
            end
            if (ready_o && !p_rdy) begin
                ready_cyc = cyc;
                busy_at_ready = int'(busy_o);
                done_at_ready = int'(done_o);
            end
            if (done_o) done_hi++;
        end
        p_clr = testclr_o; p_clk = testclk_o; p_rdy = ready_o;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic mon_reset();
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 3000 && !ready_o; k++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "testclr", int'(testclr_o), 0);
        chk("R1", "testclk", int'(testclk_o), 0);
        chk("R1", "testen", int'(testen_o), 0);
        chk("R1", "busy|done|err|ready", int'({busy_o, done_o, err_o, ready_o}), 0);
        chk("R1", "lanes", int'(lanes_o), 2);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "post-reset port", int'({testclr_o, testclk_o, testen_o, busy_o}), 0);
    endtask

    task automatic t_mid_reset();
        rate = 11'd500; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3 * HOLD + 1) @(negedge clk);
        chk("R1", "busy before mid reset", int'(busy_o), 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "mid reset port", int'({testclr_o, testclk_o, testen_o}), 0);
        chk("R1", "mid reset flags", int'({busy_o, done_o, err_o, ready_o}), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic lane_write(input logic s, input logic [1:0] v);
        shut = s; lval = v; lwr = 1'b1;
        @(negedge clk);
        lwr = 1'b0; shut = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_lanes();
        lane_write(1'b1, 2'd1); chk("R2", "write 1 in shutdown", int'(lanes_o), 1);
        lane_write(1'b1, 2'd3); chk("R2", "illegal 3 refused", int'(lanes_o), 1);
        lane_write(1'b1, 2'd0); chk("R2", "illegal 0 refused", int'(lanes_o), 1);
        lane_write(1'b0, 2'd2); chk("R2", "write out of shutdown", int'(lanes_o), 1);
        lane_write(1'b1, 2'd2); chk("R2", "write 2 in shutdown", int'(lanes_o), 2);
    endtask

    task automatic t_refuse(input string req, input logic s, input logic [10:0] r);
        mon_reset();
        shut = s; rate = r; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(req, "err after refused start", int'(err_o), 1);
        chk(req, "busy after refused start", int'(busy_o), 0);
        repeat (20) @(negedge clk);
        chk(req, "no clear pulse", clr_rises, 0);
        chk(req, "no test clock edge", addr_falls + data_falls, 0);
        chk("R12", "err sticky", int'(err_o), 1);
        shut = 1'b1;
    endtask

    task automatic run_cfg(input logic [10:0] r, input int exp_code, input bit full);
        mon_reset();
        rate = r; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R10", "busy after start", int'(busy_o), 1);
        chk("R12", "err cleared by accepted start", int'(err_o), 0);
        wait_ready();
        chk("R7", $sformatf("code for %0d", r), data_cap & 6'h3f, exp_code);
        if (full) begin
            chk("R5", "single clear pulse", clr_rises, 1);
            chk("R5", "clear before test clock", clr_first, 1);
            chk("R5", "address latched", addr_cap, 8'h44);
            chk("R6", "one data fall", data_falls, 1);
            chk("R6", "testen low at data", data_en, 0);
            chk("R6", "upper data bits", data_cap >> 6, 0);
            chk("R8", "clear width", clr_w, HOLD);
            chk("R8", "data clock width", clk_w_data, HOLD);
            chk("R9", "init delay", ready_cyc - fall_cyc, HOLD + INIT);
            chk("R10", "busy at ready", busy_at_ready, 0);
            chk("R10", "done at ready", done_at_ready, 1);
            chk("R10", "done width", done_hi, 1);
        end
    endtask

    task automatic t_busy_start();
        mon_reset();
        rate = 11'd400; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        rate = 11'd1500; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_ready();
        chk("R11", "code kept", data_cap & 6'h3f, 6'b000110);
        chk("R11", "single clear pulse", clr_rises, 1);
        chk("R11", "timing kept", ready_cyc - fall_cyc, HOLD + INIT);
    endtask

    task automatic t_concurrent();
        mon_reset();
        shut = 1'b1; lval = 2'd1; lwr = 1'b1; rate = 11'd1000; start = 1'b1;
        @(negedge clk); start = 1'b0; lwr = 1'b0;
        chk("R2", "lane write with start", int'(lanes_o), 1);
        chk("R10", "busy with lane write", int'(busy_o), 1);
        wait_ready();
        chk("R7", "code 1000 with lane write", data_cap & 6'h3f, 6'b101010);
        shut = 1'b0; lval = 2'd2; lwr = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0; lwr = 1'b0;
        chk("R2", "lane write out of shutdown with start", int'(lanes_o), 1);
        chk("R3", "err with concurrent lane write", int'(err_o), 1);
        chk("R3", "busy low", int'(busy_o), 0);
        shut = 1'b1;
    endtask

    task automatic run_all();
        t_reset();
        t_lanes();
        run_cfg(11'd80, 6'b000000, 1'b1);
        t_refuse("R3", 1'b0, 11'd400);
        t_refuse("R4", 1'b1, 11'd79);
        t_refuse("R4", 1'b1, 11'd1501);
        run_cfg(11'd89, 6'b000000, 1'b0);
        run_cfg(11'd90, 6'b010000, 1'b0);
        run_cfg(11'd110, 6'b000001, 1'b0);
        run_cfg(11'd129, 6'b000001, 1'b0);
        run_cfg(11'd400, 6'b000110, 1'b0);
        run_cfg(11'd449, 6'b000110, 1'b0);
        run_cfg(11'd1049, 6'b101010, 1'b0);
        run_cfg(11'd1450, 6'b111100, 1'b0);
        run_cfg(11'd1500, 6'b111100, 1'b1);
        t_busy_start();
        t_concurrent();
        t_mid_reset();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule